// File: doc/BRIEF.md
# Microcontroller Clock Source Selector

This block derives three system clocks from three oscillator inputs: a low-frequency crystal, a second high-frequency crystal and a digitally controlled oscillator (DCO). The CPU clock and the peripheral clock each pick their source through their own multiplexer. The low-speed auxiliary clock always runs from the low-frequency crystal. Each output then passes through its own prescaler, which divides by 1, 2, 4 or 8. Software programs the sources, the prescalers and the settings passed to the analog oscillators through four byte-wide registers on a simple synchronous register bus.

The analog parts are modelled only as clock pins and fault pins. The DCO tuning fields are stored and presented on output ports for the analog macro. An oscillator-fault flag is set while any enabled crystal reports a fault. Software can write it to zero, but it is set again while the fault remains. An enable bit gates this flag onto an interrupt request. Setting the second-crystal-off bit counts as a fault of that crystal and gates its clock away.

The parameter `HAS_XT2` builds the block with or without the second crystal. When the crystal is absent, every selection that would pick it picks the low-frequency crystal instead.

Top module: `clk_src_select`

## Requirements
- R1: After the asynchronous reset, the registers read as follows: address 0 (DCO tuning) reads 0x60, address 1 (oscillator control) reads 0x84 and address 2 (clock routing) reads 0x00.
- R2: The auxiliary clock runs from the low-frequency crystal, divided by 2^N. N is bits 5:4 of address 1.
- R3: Bits 7:6 of address 2 select the CPU clock source: codes 0 and 1 select the DCO, code 2 selects the second crystal and code 3 selects the low-frequency crystal. Both the CPU clock and the peripheral clock run from the DCO after reset.
- R4: The CPU clock is the selected source divided by 2^N. N is bits 5:4 of address 2.
- R5: Bit 3 of address 2 selects the peripheral clock source: 0 selects the DCO and 1 selects the crystal. The peripheral clock is divided by 2^N, where N is bits 2:1 of address 2.
- R6: A new source or divide setting takes effect only at the end of the divided period in progress. The first period after the change starts with a rising edge at that boundary.
- R7: Address 3 bit 0 is the fault flag. It is set whenever the synchronised fault is active, whether or not a write occurs. Writing 0 to it clears it only if no fault is present.
- R8: The interrupt output is high only when the fault flag is set and the enable bit (address 3 bit 1) is set.
- R9: Bit 7 of address 1 turns the second crystal off. While it is set, that crystal counts as faulty, its enable output is low, and a CPU clock routed to it has no edges.
- R10: The DCO step (address 0 bits 7:5), the modulation (bits 4:0), the range (address 1 bits 2:0), the crystal high-frequency mode (address 1 bit 6) and the external-resistor enable (address 2 bit 0) drive their output ports directly.
- R11: Address 1 bit 3 and address 3 bits 7:2 always read 0.
- R12: With `HAS_XT2` = 0, a peripheral clock set to crystal and a CPU clock set to code 2 both run from the low-frequency crystal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| lf_clk | input | 1 | Low-frequency crystal clock |
| hf2_clk | input | 1 | Second high-frequency crystal clock |
| dco_clk | input | 1 | DCO clock |
| lf_fault | input | 1 | Low-frequency crystal fault indication |
| hf2_fault | input | 1 | Second crystal fault indication |
| aclk | output | 1 | Auxiliary low-speed clock |
| mclk | output | 1 | CPU clock |
| smclk | output | 1 | Peripheral clock |
| osc_irq | output | 1 | Oscillator-fault interrupt request |
| dco_step | output | 3 | DCO frequency step |
| dco_mod | output | 5 | DCO modulation |
| range_sel | output | 3 | DCO range select |
| lf_hf_mode | output | 1 | Low-frequency crystal in high-frequency mode |
| hf2_enable | output | 1 | Second crystal oscillator enable |
| ext_res_en | output | 1 | External DCO resistor enable |

## Verification
The bench builds two copies of the block on the same register bus. One has `HAS_XT2` = 1 and covers every source code, every divide code, the fault path through the second crystal and the stopped clock when that crystal is switched off. The other has `HAS_XT2` = 0 and shows that crystal selections fall back to the low-frequency crystal. The three oscillator clocks have distinct periods (10, 16 and 40 ns), so each measured output period identifies both the source and the divider.

// File: rtl/clk_src_select.sv
module clk_src_select #(
  parameter bit HAS_XT2 = 1'b1
) (
  input  logic       bus_clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       lf_clk,
  input  logic       hf2_clk,
  input  logic       dco_clk,
  input  logic       lf_fault,
  input  logic       hf2_fault,
  output logic       aclk,
  output logic       mclk,
  output logic       smclk,
  output logic       osc_irq,
  output logic [2:0] dco_step,
  output logic [4:0] dco_mod,
  output logic [2:0] range_sel,
  output logic       lf_hf_mode,
  output logic       hf2_enable,
  output logic       ext_res_en
);
  localparam logic [1:0] SRC_DCO = 2'd0;
  localparam logic [1:0] SRC_HF2 = 2'd1;
  localparam logic [1:0] SRC_LF  = 2'd2;
  localparam logic [1:0] SRC_XT  = HAS_XT2 ? SRC_HF2 : SRC_LF;
  localparam int         NOUT    = 3;
  localparam int         CNTW    = 3;

  logic [7:0] r_dco, r_osc, r_rt;
  logic       irq_en, flag, fs1, fs2;
  logic       hf2_g, fault_any;
  logic [1:0] req_src [NOUT];
  logic [1:0] req_div [NOUT];
  logic [NOUT-1:0] clk_o;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_dco  <= 8'h60;
      r_osc  <= 8'h84;
      r_rt   <= 8'h00;
      irq_en <= 1'b0;
    end else if (wr) begin
      case (addr)
        2'd0: r_dco  <= wdata;
        2'd1: r_osc  <= wdata & 8'hF7;
        2'd2: r_rt   <= wdata;
        default: irq_en <= wdata[1];
      endcase
    end
  end

  assign hf2_enable = HAS_XT2 && !r_osc[7];
  assign hf2_g      = hf2_clk & hf2_enable;
  assign fault_any  = lf_fault | (HAS_XT2 && (r_osc[7] | hf2_fault));

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      fs1  <= 1'b0;
      fs2  <= 1'b0;
      flag <= 1'b0;
    end else begin
      fs1  <= fault_any;
      fs2  <= fs1;
      flag <= fs2 | ((wr && addr == 2'd3) ? wdata[0] : flag);
    end
  end

  assign osc_irq = flag & irq_en;

  always_comb begin
    case (addr)
      2'd0:    rdata = r_dco;
      2'd1:    rdata = r_osc;
      2'd2:    rdata = r_rt;
      default: rdata = {6'b0, irq_en, flag};
    endcase
  end

  assign dco_step   = r_dco[7:5];
  assign dco_mod    = r_dco[4:0];
  assign range_sel  = r_osc[2:0];
  assign lf_hf_mode = r_osc[6];
  assign ext_res_en = r_rt[0];

  assign req_src[0] = SRC_LF;
  assign req_div[0] = r_osc[5:4];
  assign req_src[1] = !r_rt[7] ? SRC_DCO : (r_rt[6] ? SRC_LF : SRC_XT);
  assign req_div[1] = r_rt[5:4];
  assign req_src[2] = r_rt[3] ? SRC_XT : SRC_DCO;
  assign req_div[2] = r_rt[2:1];

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam logic [1:0] SRC_RST = (i == 0) ? SRC_LF : SRC_DCO;
    logic [1:0]      src_q, div_q;
    logic [CNTW-1:0] cnt, mask;
    logic            sclk, wrap;

    always_comb begin
      case (src_q)
        SRC_DCO: sclk = dco_clk;
        SRC_HF2: sclk = hf2_g;
        default: sclk = lf_clk;
      endcase
    end

    assign mask = (CNTW'(1) << div_q) - CNTW'(1);
    assign wrap = (cnt & mask) == mask;

    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
        cnt   <= '0;
        src_q <= SRC_RST;
        div_q <= 2'd0;
      end else if (wrap) begin
        cnt   <= '0;
        src_q <= req_src[i];
        div_q <= req_div[i];
      end else begin
        cnt <= cnt + CNTW'(1);
      end
    end

    always_comb begin
      case (div_q)
        2'd0:    clk_o[i] = sclk;
        2'd1:    clk_o[i] = ~cnt[0];
        2'd2:    clk_o[i] = ~cnt[1];
        default: clk_o[i] = ~cnt[2];
      endcase
    end
  end

  assign aclk  = clk_o[0];
  assign mclk  = clk_o[1];
  assign smclk = clk_o[2];
endmodule

// File: rtl/clk_src_select_chk.sv
module clk_src_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       fault_s,
  input logic       flag,
  input logic       en,
  input logic       irq,
  input logic [2:0] dco_step
);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && !wdata[0] && !fault_s) |=> !flag);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  // R11
  unused_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> (rdata[3] == 1'b0));

  // R11
  flag_reg_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata[7:2] == 6'd0));

  // R10
  dco_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0) |=> (dco_step == $past(wdata[7:5])));
endmodule

bind clk_src_select clk_src_select_chk u_chk (
  .clk(bus_clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
  .rdata(rdata), .fault_s(fs2), .flag(flag), .en(irq_en), .irq(osc_irq),
  .dco_step(dco_step)
);

// File: tb/clk_src_select_test.sv
`timescale 1ns/1ps
module clk_src_select_test;
  localparam int CLK_PERIOD = 8;

  logic bus_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata, rdata_nx;
  logic lf_clk = 1'b0, hf2_clk = 1'b0, dco_clk = 1'b0;
  logic lf_fault = 1'b0, hf2_fault = 1'b0;
  logic aclk, mclk, smclk, osc_irq;
  logic aclk_nx, mclk_nx, smclk_nx, osc_irq_nx;
  logic [2:0] dco_step, range_sel, dco_step_nx, range_sel_nx;
  logic [4:0] dco_mod, dco_mod_nx;
  logic lf_hf_mode, hf2_enable, ext_res_en;
  logic lf_hf_mode_nx, hf2_enable_nx, ext_res_en_nx;
  int checks = 0, failures = 0;
  int mclk_edges = 0;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #5  dco_clk = ~dco_clk;
  always #8  hf2_clk = ~hf2_clk;
  always #20 lf_clk  = ~lf_clk;
  always @(posedge mclk) mclk_edges++;

  clk_src_select #(.HAS_XT2(1'b1)) uut (
    .bus_clk, .rst_n, .addr, .wr, .wdata, .rdata,
    .lf_clk, .hf2_clk, .dco_clk, .lf_fault, .hf2_fault,
    .aclk, .mclk, .smclk, .osc_irq, .dco_step, .dco_mod, .range_sel,
    .lf_hf_mode, .hf2_enable, .ext_res_en);

  clk_src_select #(.HAS_XT2(1'b0)) uut_nx (
    .bus_clk, .rst_n, .addr, .wr, .wdata, .rdata(rdata_nx),
    .lf_clk, .hf2_clk, .dco_clk, .lf_fault, .hf2_fault,
    .aclk(aclk_nx), .mclk(mclk_nx), .smclk(smclk_nx), .osc_irq(osc_irq_nx),
    .dco_step(dco_step_nx), .dco_mod(dco_mod_nx), .range_sel(range_sel_nx),
    .lf_hf_mode(lf_hf_mode_nx), .hf2_enable(hf2_enable_nx),
    .ext_res_en(ext_res_en_nx));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge bus_clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int d);
    @(negedge bus_clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  task automatic wait_edge(input int sel);
    case (sel)
      0: @(posedge aclk);
      1: @(posedge mclk);
      2: @(posedge smclk);
      3: @(posedge smclk_nx);
      default: @(posedge mclk_nx);
    endcase
  endtask

  task automatic period(input int sel, output int p);
    realtime t0;
    for (int k = 0; k < 3; k++) wait_edge(sel);
    t0 = $realtime;
    wait_edge(sel);
    p = $rtoi($realtime - t0 + 0.5);
  endtask

  task automatic t_reset();
    int v;
    bus_read(2'd0, v); check("R1 dco reg", v, 8'h60);
    bus_read(2'd1, v); check("R1 osc reg", v, 8'h84);
    bus_read(2'd2, v); check("R1 route reg", v, 8'h00);
    check("R10 step", int'(dco_step), 3);
    check("R10 range", int'(range_sel), 4);
    check("R9 hf2 off at reset", int'(hf2_enable), 0);
    period(1, v); check("R3 mclk reset dco", v, 10);
    period(2, v); check("R3 smclk reset dco", v, 10);
    period(0, v); check("R2 aclk div1", v, 40);
  endtask

  task automatic t_aclk_div();
    int v;
    for (int d = 1; d < 4; d++) begin
      bus_write(2'd1, 8'h84 | 8'(d << 4));
      period(0, v); check("R2 aclk div", v, 40 << d);
    end
    bus_write(2'd1, 8'h04);
  endtask

  task automatic t_mclk();
    int v;
    bus_write(2'd2, 8'h40); period(1, v); check("R3 mclk code1 dco", v, 10);
    bus_write(2'd2, 8'h80); period(1, v); check("R3 mclk code2 hf2", v, 16);
    bus_write(2'd2, 8'hE0); period(1, v); check("R4 mclk lf div4", v, 160);
    bus_write(2'd2, 8'h90); period(1, v); check("R4 mclk hf2 div2", v, 32);
    bus_write(2'd2, 8'h30); period(1, v); check("R4 mclk dco div8", v, 80);
    period(4, v); check("R12 nx mclk dco div8", v, 80);
    bus_write(2'd2, 8'h80); period(4, v); check("R12 nx mclk code2 lf", v, 40);
  endtask

  task automatic t_smclk();
    int v;
    bus_write(2'd2, 8'h0C); period(2, v); check("R5 smclk xt div4", v, 64);
    period(3, v); check("R12 nx smclk lf div4", v, 160);
    bus_write(2'd2, 8'h02); period(2, v); check("R5 smclk dco div2", v, 20);
    bus_write(2'd2, 8'h00);
  endtask

  task automatic t_boundary();
    int v;
    realtime t0, t1, t2;
    bus_write(2'd2, 8'h30); period(1, v);
    wait_edge(1); t0 = $realtime;
    bus_write(2'd2, 8'h00);
    wait_edge(1); t1 = $realtime;
    wait_edge(1); t2 = $realtime;
    check("R6 old period completes", $rtoi(t1 - t0 + 0.5), 80);
    check("R6 new period after boundary", $rtoi(t2 - t1 + 0.5), 10);
  endtask

  task automatic t_fault();
    int v;
    bus_write(2'd1, 8'h04);
    bus_write(2'd3, 8'h00);
    repeat (5) @(negedge bus_clk);
    bus_read(2'd3, v); check("R7 flag cleared", v, 0);
    hf2_fault = 1'b1;
    repeat (5) @(negedge bus_clk);
    bus_read(2'd3, v); check("R7 flag set by fault", v, 1);
    check("R8 irq masked", int'(osc_irq), 0);
    bus_write(2'd3, 8'h02);
    repeat (5) @(negedge bus_clk);
    bus_read(2'd3, v); check("R7 sticky while fault", v, 3);
    check("R8 irq enabled", int'(osc_irq), 1);
    hf2_fault = 1'b0;
    repeat (5) @(negedge bus_clk);
    bus_read(2'd3, v); check("R7 stays after fault ends", v, 3);
    bus_write(2'd3, 8'h02);
    bus_read(2'd3, v); check("R7 clear after fault ends", v, 2);
    check("R8 irq drops", int'(osc_irq), 0);
    bus_write(2'd1, 8'h84);
    repeat (5) @(negedge bus_clk);
    bus_read(2'd3, v); check("R9 off forces fault", v, 3);
    bus_write(2'd1, 8'h04);
    bus_write(2'd3, 8'h00);
    lf_fault = 1'b1;
    repeat (5) @(negedge bus_clk);
    bus_read(2'd3, v); check("R7 lf fault sets flag", v, 1);
    lf_fault = 1'b0;
    bus_write(2'd3, 8'h00);
  endtask

  task automatic t_unused();
    int v;
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, v); check("R11 osc unused bit", v, 8'hF7);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, v); check("R11 flag reg upper", v, 3);
    check("R10 hf mode", int'(lf_hf_mode), 1);
    check("R10 range", int'(range_sel), 7);
    bus_write(2'd1, 8'h04);
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'hA5);
    check("R10 step", int'(dco_step), 5);
    check("R10 mod", int'(dco_mod), 5);
    bus_write(2'd2, 8'h01);
    check("R10 ext res", int'(ext_res_en), 1);
    bus_write(2'd2, 8'h00);
  endtask

  task automatic t_xt2off();
    int v, e0;
    bus_write(2'd2, 8'h80); period(1, v); check("R9 mclk hf2 running", v, 16);
    bus_write(2'd1, 8'h84);
    #200;
    e0 = mclk_edges;
    #500;
    check("R9 mclk stopped", mclk_edges - e0, 0);
    check("R9 enable low", int'(hf2_enable), 0);
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h04);
    period(1, v); check("R3 mclk back on dco", v, 10);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bus_clk);
    rst_n = 1'b1;
    t_reset();
    t_aclk_div();
    t_mclk();
    t_smclk();
    t_boundary();
    t_fault();
    t_unused();
    t_xt2off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule